// File: doc/BRIEF.md
# Programmable Serial Transceiver with Fractional Stop Length

This block is an asynchronous serial transmitter and receiver driven through an 8-bit register port. A divider makes an oversampling tick, and every bit on the line lasts 32 of those ticks. Software sets the character format: 5 to 8 data bits, a parity setting for each direction, and a stop period set in eighths of a bit. Characters wait in a 16-entry transmit queue and a 16-entry receive queue.

Each queue drives an interrupt output through a level threshold. A receive idle timeout, counted in whole character times, catches the characters that stay in a receive queue that has not reached its threshold. Software can force a break on the line, and an internal loopback joins the transmitter to the receiver while the external pin stays idle.

A receive queue entry holds the character together with its parity and framing error flags. Software reads the flags of the entry at the head of the queue before it pops that entry.

Top module: `uart_core`

## Requirements
- R1: The oversampling tick occurs once every 2*(1+div) clocks. The 16-bit divisor div is split into a low byte at address 5 and a high byte at address 6. Every transmitted bit lasts 32 ticks, which is 64*(1+div) clocks.
- R2: Bits [5:4] of the format register (address 2) select the data length. Code k gives 5+k data bits, sent least significant bit first. The receiver returns the character right-aligned, with the unused upper bits at zero.
- R3: Bits [3:0] of the format register set the stop period. Code n gives (n+1)/8 of a bit, which is 4*(n+1) ticks. When queued characters follow each other, the distance from one start edge to the next is (1+data bits+parity bits)*32 + 4*(n+1) ticks.
- R4: While bit 6 of the format register is 1, the transmit line is held low. When the bit clears, the line takes up its normal level again.
- R5: The control register (address 1) has these bits, MSB first: tick enable, transmit enable, receive enable, loopback, transmit parity on, transmit parity even, receive parity on, receive parity even. With even parity, the parity bit makes the count of ones over data and parity even. Odd parity makes that count odd.
- R6: Each receive entry holds the character and two flags. A read of address 7 returns them: bit 0 is a parity mismatch and bit 1 is a framing error, which means the line was low at the middle of the first stop bit. A read of address 0 returns the character and pops the entry.
- R7: With loopback on, the transmitted bit stream goes straight into the receiver and the external txd pin stays high.
- R8: A write to address 3 with bit 7 set empties the transmit queue. Bit 6 set empties the receive queue. Both bits read back as 0. Bits [4:0] of address 3 store the timeout count.
- R9: irq_tx is high while the transmit level is below bits [7:4] of address 4. irq_rx is high while the receive level is above bits [3:0] of address 4.
- R10: irq_rx is also raised when the timeout count is nonzero, the receive queue is not empty, its level is at or below the receive threshold, and that count of idle character times has passed since the last push or pop.
- R11: With transmit disabled, no character leaves the queue and the line stays high. With receive disabled, no character is taken in.
- R12: After reset, the control register, thresholds, divisor and timeout count are 0, the format register is 0x37, both queues are empty, txd is high and both interrupts are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 0 pops the receive queue |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr, combinational |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_tx | output | 1 | Transmit level below threshold |
| irq_rx | output | 1 | Receive level above threshold, or idle timeout |

## Verification
The transmit engine is timed on the external pin with bytes of all zeros and all ones. The width of the low run and the spacing of start edges then separate the data length, the parity bit and its sense, the stop fraction and the divisor from one another. Loopback sweeps cover every data length, several byte values and three parity settings, so that truncation, bit order and parity generation are each compared with values the bench computes. A deliberate parity mismatch between the two directions, and a break held across a whole frame, check that each error flag is set on its own. Level and timeout interrupts are sampled on both sides of their boundaries.

// File: rtl/uart_pkg.sv
// Shared types, register addresses and helper functions for the serial transceiver.
// Assumes a byte-wide register port and characters of at most 8 data bits.
package uart_pkg;
    localparam int TICKS_PER_BIT = 32;
    localparam int MID_BIT       = 16;

    typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} frame_st_t;

    typedef struct packed {
        logic       ferr;
        logic       perr;
        logic [7:0] data;
    } rx_word_t;

    localparam logic [2:0] A_DATA = 3'd0;
    localparam logic [2:0] A_CTRL = 3'd1;
    localparam logic [2:0] A_CFG  = 3'd2;
    localparam logic [2:0] A_FCTL = 3'd3;
    localparam logic [2:0] A_THR  = 3'd4;
    localparam logic [2:0] A_DIVL = 3'd5;
    localparam logic [2:0] A_DIVH = 3'd6;
    localparam logic [2:0] A_RXST = 3'd7;

    // Mask keeping the 5+len low data bits.
    function automatic logic [7:0] len_mask(input logic [1:0] len);
        return 8'hFF >> (2'd3 - len);
    endfunction

    // Parity bit for a masked character: even makes the total count of ones even.
    function automatic logic par_bit(input logic [7:0] d, input logic even);
        return even ? (^d) : ~(^d);
    endfunction
endpackage

// File: rtl/uart_baud.sv
// Oversampling tick generator: one tick every 2*(1+div) clocks while enabled.
// Assumes div may change at any time; the counter wraps at or above the new limit.
module uart_baud #(
    parameter int DIVW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);
    logic [DIVW:0] cnt;
    logic [DIVW:0] lim;

    assign lim  = {div, 1'b1};
    assign tick = en && (cnt >= lim);

    // Count clocks up to the limit, then start again.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  cnt <= '0;
        else if (cnt >= lim) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/uart_fifo.sv
// Synchronous FIFO with a level output and a flush input that has priority.
// Assumes DEPTH is a power of two; a push when full or a pop when empty is dropped.
module uart_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = AW + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] wdata,
    input  logic         pop,
    output logic [W-1:0] rdata,
    output logic [LW-1:0] level,
    output logic         empty,
    output logic         full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == LW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    // Store an accepted entry.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Move pointers and the level.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp <= '0; rp <= '0; level <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            level <= level + LW'(do_push) - LW'(do_pop);
        end
    end
endmodule

// File: rtl/uart_tx.sv
// Transmit engine: start bit, 5..8 data bits LSB first, optional parity, stop of (n+1)/8 bit.
// Assumes a tick at 32 per bit; a queued character follows the stop period with no gap.
module uart_tx
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       en,
    input  logic [1:0] len,
    input  logic [3:0] stop,
    input  logic       par_en,
    input  logic       par_even,
    input  logic       q_empty,
    input  logic [7:0] q_data,
    output logic       pop,
    output logic       line
);
    frame_st_t  st;
    logic [5:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       par;
    logic [5:0] stop_last;
    logic       bit_end, last_bit, load;
    logic [7:0] masked;

    assign stop_last = {stop, 2'b11};
    assign bit_end   = (tcnt == 6'(TICKS_PER_BIT - 1));
    assign last_bit  = (bidx == ({1'b0, len} + 3'd4));
    assign masked    = q_data & len_mask(len);
    assign load      = en && !q_empty && tick &&
                       ((st == S_IDLE) || (st == S_STOP && tcnt == stop_last));
    assign pop       = load;

    // Frame sequencer advanced by the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0; par <= 1'b0;
        end else if (load) begin
            st <= S_START; tcnt <= '0; bidx <= '0; sh <= masked;
            par <= par_bit(masked, par_even);
        end else if (tick) begin
            case (st)
                S_START: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) st <= S_DATA;
                end
                S_DATA: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) begin
                        sh <= sh >> 1;
                        if (last_bit) st <= par_en ? S_PAR : S_STOP;
                        else          bidx <= bidx + 1'b1;
                    end
                end
                S_PAR: begin
                    tcnt <= bit_end ? '0 : tcnt + 1'b1;
                    if (bit_end) st <= S_STOP;
                end
                S_STOP: begin
                    if (tcnt == stop_last) begin st <= S_IDLE; tcnt <= '0; end
                    else tcnt <= tcnt + 1'b1;
                end
                default: tcnt <= '0;
            endcase
        end
    end

    // Line level for the current frame part.
    always_comb begin
        case (st)
            S_START: line = 1'b0;
            S_DATA:  line = sh[0];
            S_PAR:   line = par;
            default: line = 1'b1;
        endcase
    end
endmodule

// File: rtl/uart_rx.sv
// Receive engine: falling edge starts a frame, confirmed at tick 16; bits sampled mid-bit.
// Assumes a synchronised input line; one stop bit is sampled and a low sample is a framing error.
module uart_rx
    import uart_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     en,
    input  logic     line,
    input  logic [1:0] len,
    input  logic     par_en,
    input  logic     par_even,
    output logic     push,
    output rx_word_t word
);
    frame_st_t  st;
    logic [4:0] tcnt;
    logic [2:0] bidx;
    logic [7:0] sh;
    logic       line_q, par_smp;
    logic       mid, last_bit;
    logic [7:0] data;

    assign mid      = (tcnt == 5'(TICKS_PER_BIT - 1));
    assign last_bit = (bidx == ({1'b0, len} + 3'd4));
    assign data     = sh >> (2'd3 - len);
    assign push     = tick && (st == S_STOP) && mid;
    assign word     = '{ferr: !line,
                        perr: par_en && (par_smp != par_bit(data, par_even)),
                        data: data};

    // Frame tracker advanced by the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= S_IDLE; tcnt <= '0; bidx <= '0; sh <= '0; line_q <= 1'b1; par_smp <= 1'b0;
        end else if (tick) begin
            line_q <= line;
            case (st)
                S_IDLE: if (en && line_q && !line) begin st <= S_START; tcnt <= '0; end
                S_START: begin
                    if (tcnt == 5'(MID_BIT - 1)) begin
                        tcnt <= '0; bidx <= '0;
                        st <= line ? S_IDLE : S_DATA;
                    end else tcnt <= tcnt + 1'b1;
                end
                S_DATA: begin
                    tcnt <= tcnt + 1'b1;
                    if (mid) begin
                        sh <= {line, sh[7:1]};
                        if (last_bit) st <= par_en ? S_PAR : S_STOP;
                        else          bidx <= bidx + 1'b1;
                    end
                end
                S_PAR: begin
                    tcnt <= tcnt + 1'b1;
                    if (mid) begin par_smp <= line; st <= S_STOP; end
                end
                S_STOP: begin
                    tcnt <= tcnt + 1'b1;
                    if (mid) st <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rxtmo.sv
// Idle timer counting whole character times for the current frame format, saturating at 31.
// Assumes restart is held while the receive queue is empty.
module uart_rxtmo
    import uart_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       restart,
    input  logic [1:0] len,
    input  logic       par_en,
    input  logic [4:0] limit,
    output logic       reached
);
    logic [4:0] tcnt;
    logic [3:0] bcnt;
    logic [4:0] ccnt;
    logic [3:0] bits_last;
    logic       bit_end;

    assign bits_last = 4'd6 + {2'b0, len} + {3'b0, par_en};
    assign bit_end   = (tcnt == 5'(TICKS_PER_BIT - 1));
    assign reached   = (limit != '0) && (ccnt >= limit);

    // Tick, bit and character counters, cleared on restart.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            tcnt <= '0; bcnt <= '0; ccnt <= '0;
        end else if (tick) begin
            tcnt <= tcnt + 1'b1;
            if (bit_end) begin
                if (bcnt >= bits_last) begin
                    bcnt <= '0;
                    if (ccnt != 5'd31) ccnt <= ccnt + 1'b1;
                end else bcnt <= bcnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/uart_core.sv
// Serial transceiver top: register file, tick divider, both engines, queues and interrupts.
// Assumes single-cycle register strobes; reg_rdata is combinational on reg_addr.
module uart_core
    import uart_pkg::*;
#(
    parameter int DIVW       = 16,
    parameter int FIFO_DEPTH = 16,
    localparam int LW        = $clog2(FIFO_DEPTH) + 1,
    localparam int RXW       = $bits(rx_word_t)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_tx,
    output logic       irq_rx
);
    logic [7:0]      ctrl_q, cfg_q, thr_q;
    logic [4:0]      tmo_q;
    logic [DIVW-1:0] div_q;
    logic            tick, tx_pop, tx_line, rx_push, tmo_hit;
    logic            flush_tx, flush_rx, tx_push, rx_pop;
    logic            tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]      tx_head;
    logic [LW-1:0]   tx_lvl, rx_lvl;
    rx_word_t        rx_in, rx_head;
    logic            line_int, rx_s1, rx_s2;

    assign flush_tx = reg_wr && reg_addr == A_FCTL && reg_wdata[7];
    assign flush_rx = reg_wr && reg_addr == A_FCTL && reg_wdata[6];
    assign tx_push  = reg_wr && reg_addr == A_DATA;
    assign rx_pop   = reg_rd && reg_addr == A_DATA;

    // Control, format, timeout, threshold and divisor registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0; cfg_q <= 8'h37; thr_q <= '0; tmo_q <= '0; div_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: ctrl_q <= reg_wdata;
                A_CFG:  cfg_q  <= reg_wdata;
                A_FCTL: tmo_q  <= reg_wdata[4:0];
                A_THR:  thr_q  <= reg_wdata;
                A_DIVL: div_q[7:0] <= reg_wdata;
                A_DIVH: div_q[DIVW-1:8] <= reg_wdata[DIVW-9:0];
                default: ;
            endcase
        end
    end

    // Read-back multiplexer.
    always_comb begin
        case (reg_addr)
            A_DATA:  reg_rdata = rx_head.data;
            A_CTRL:  reg_rdata = ctrl_q;
            A_CFG:   reg_rdata = cfg_q;
            A_FCTL:  reg_rdata = {3'b000, tmo_q};
            A_THR:   reg_rdata = thr_q;
            A_DIVL:  reg_rdata = div_q[7:0];
            A_DIVH:  reg_rdata = 8'(div_q[DIVW-1:8]);
            default: reg_rdata = {6'b0, rx_head.ferr, rx_head.perr};
        endcase
    end

    uart_baud #(.DIVW(DIVW)) u_baud (
        .clk(clk), .rst_n(rst_n), .en(ctrl_q[7]), .div(div_q), .tick(tick)
    );

    uart_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(tx_push), .wdata(reg_wdata),
        .pop(tx_pop), .rdata(tx_head), .level(tx_lvl), .empty(tx_empty), .full(tx_full)
    );

    uart_tx u_tx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q[6]), .len(cfg_q[5:4]),
        .stop(cfg_q[3:0]), .par_en(ctrl_q[3]), .par_even(ctrl_q[2]),
        .q_empty(tx_empty), .q_data(tx_head), .pop(tx_pop), .line(tx_line)
    );

    assign line_int = tx_line && !cfg_q[6];
    assign txd      = ctrl_q[4] ? 1'b1 : line_int;

    // Two-stage synchroniser on the selected receive source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin rx_s1 <= 1'b1; rx_s2 <= 1'b1; end
        else begin rx_s1 <= ctrl_q[4] ? line_int : rxd; rx_s2 <= rx_s1; end
    end

    uart_rx u_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .en(ctrl_q[5]), .line(rx_s2),
        .len(cfg_q[5:4]), .par_en(ctrl_q[1]), .par_even(ctrl_q[0]),
        .push(rx_push), .word(rx_in)
    );

    uart_fifo #(.W(RXW), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(rx_push), .wdata(rx_in),
        .pop(rx_pop), .rdata(rx_head), .level(rx_lvl), .empty(rx_empty), .full(rx_full)
    );

    uart_rxtmo u_tmo (
        .clk(clk), .rst_n(rst_n), .tick(tick), .restart(rx_push || rx_pop || rx_empty),
        .len(cfg_q[5:4]), .par_en(ctrl_q[1]), .limit(tmo_q), .reached(tmo_hit)
    );

    assign irq_tx = tx_lvl < LW'(thr_q[7:4]);
    assign irq_rx = (rx_lvl > LW'(thr_q[3:0])) ||
                    (tmo_hit && !rx_empty && rx_lvl <= LW'(thr_q[3:0]));
endmodule

// File: rtl/uart_core_chk.sv
// Property checker for uart_core, attached by bind; observes ports and internal strobes.
// Assumes the default parameters for level widths passed through LW.
module uart_core_chk #(
    parameter int FIFO_DEPTH = 16,
    parameter int LW         = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick,
    input logic          tx_pop,
    input logic          rx_push,
    input logic          irq_rx,
    input logic [7:0]    ctrl_q,
    input logic [7:0]    thr_q,
    input logic [LW-1:0] tx_lvl,
    input logic [LW-1:0] rx_lvl,
    input logic          reg_wr,
    input logic [2:0]    reg_addr,
    input logic [7:0]    reg_wdata
);
    // R1: the tick never fires on two consecutive clocks.
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n) tick |=> !tick);
    // R1: the transmit queue is only drained on a tick.
    p_pop_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> tick);
    // R1: received characters are only stored on a tick.
    p_push_on_tick_r1: assert property (@(posedge clk) disable iff (!rst_n) rx_push |-> tick);
    // R11: nothing leaves the transmit queue while transmit is disabled.
    p_no_pop_disabled_r11: assert property (@(posedge clk) disable iff (!rst_n) !ctrl_q[6] |-> !tx_pop);
    // R8: a transmit flush leaves the queue empty.
    p_flush_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && reg_wdata[7]) |=> (tx_lvl == '0));
    // R8: a receive flush leaves the queue empty.
    p_flush_rx_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 3'd3 && reg_wdata[6]) |=> (rx_lvl == '0));
    // R8: levels never exceed the queue depth.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LW'(FIFO_DEPTH)) && (rx_lvl <= LW'(FIFO_DEPTH)));
    // R9: a receive level above threshold always shows on irq_rx.
    p_rx_level_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_lvl > LW'(thr_q[3:0])) |-> irq_rx);
endmodule

bind uart_core uart_core_chk #(.FIFO_DEPTH(FIFO_DEPTH), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tx_pop(tx_pop), .rx_push(rx_push),
    .irq_rx(irq_rx), .ctrl_q(ctrl_q), .thr_q(thr_q), .tx_lvl(tx_lvl), .rx_lvl(rx_lvl),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata)
);

// File: tb/sim_uart_core.sv
// Self-checking bench for uart_core: timing sweeps on the pin, loopback sweeps, interrupts.
module sim_uart_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_tx, irq_rx;
    int         checks = 0, errors = 0;
    logic       done = 1'b0;

    always #5 clk = ~clk;

    uart_core u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .rxd(rxd), .txd(txd),
        .irq_tx(irq_tx), .irq_rx(irq_rx)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Width in clocks of the next low run on txd.
    task automatic low_width(output int n);
        int g = 0;
        n = 0;
        while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (txd === 1'b0 && n < 5000) begin @(negedge clk); n++; end
    endtask

    // Clocks between two successive falling edges on txd.
    task automatic edge_period(output int n);
        int g = 0;
        n = 0;
        while (txd !== 1'b0 && g < 5000) begin @(negedge clk); g++; end
        while (txd === 1'b0 && n < 5000) begin @(negedge clk); n++; end
        while (txd === 1'b1 && n < 10000) begin @(negedge clk); n++; end
    endtask

    task automatic wait_rx(output int ok);
        int g = 0;
        while (irq_rx !== 1'b1 && g < 4000) begin @(negedge clk); g++; end
        ok = (irq_rx === 1'b1);
    endtask

    task automatic clean();
        wr(3'd1, 8'h00); wr(3'd3, 8'hC0); wr(3'd4, 8'h00); idle(4);
    endtask

    initial begin : watchdog
        for (int i = 0; i < 190000; i++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v, fl;
        int n, ok;
        logic [7:0] bytes [6] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h3C, 8'h81};
        logic [7:0] pars [3] = '{8'h00, 8'h0A, 8'h0F};

        idle(3); rst_n = 1'b1; idle(2);
        // R12 reset state
        chk("R12 txd", txd, 1); chk("R12 irq_tx", irq_tx, 0); chk("R12 irq_rx", irq_rx, 0);
        rd(3'd2, v); chk("R12 format", v, 8'h37);
        rd(3'd1, v); chk("R12 control", v, 0);
        rd(3'd5, v); chk("R12 div", v, 0);

        // R11 transmit disabled keeps the line high
        wr(3'd1, 8'h80); wr(3'd0, 8'h00); idle(300);
        chk("R11 tx disabled line", txd, 1);
        clean();

        // R1 start bit width for two divisors (byte 0xFF: only the start bit is low)
        for (int d = 0; d < 3; d += 2) begin
            wr(3'd5, 8'(d)); wr(3'd2, 8'h37); wr(3'd1, 8'hC0); wr(3'd0, 8'hFF);
            low_width(n); chk("R1 bit width", n, 64 * (1 + d));
            idle(64 * (1 + d) * 10); clean();
        end
        wr(3'd5, 8'h00);

        // R2/R5 low run of byte 0x00 across lengths and parity modes
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                wr(3'd2, 8'((len << 4) | 7));
                wr(3'd1, 8'hC0 | (pm == 1 ? 8'h08 : pm == 2 ? 8'h0C : 8'h00));
                wr(3'd0, 8'h00);
                low_width(n);
                chk(pm == 0 ? "R2 data length" : "R5 parity sense", n,
                    64 * (1 + 5 + len + (pm == 2 ? 1 : 0)));
                idle(900); clean();
            end
        end

        // R3 start-edge spacing for stop codes 0, 7, 15 (8 data bits, byte 0xFF)
        for (int k = 0; k < 3; k++) begin
            int sc = (k == 0) ? 0 : (k == 1) ? 7 : 15;
            wr(3'd2, 8'(8'h30 | sc)); wr(3'd0, 8'hFF); wr(3'd0, 8'hFF); wr(3'd1, 8'hC0);
            edge_period(n);
            chk("R3 stop fraction", n, 9 * 64 + (sc + 1) * 8);
            idle(1500); clean();
        end

        // R4 break forces and releases the line
        wr(3'd2, 8'h77); idle(2); chk("R4 break low", txd, 0);
        wr(3'd2, 8'h37); idle(2); chk("R4 break release", txd, 1);

        // R2/R5/R6/R7 loopback sweep over lengths, parity settings and byte values
        for (int len = 0; len < 4; len++) begin
            for (int pm = 0; pm < 3; pm++) begin
                wr(3'd2, 8'((len << 4) | 7));
                wr(3'd1, 8'hF0 | pars[pm]);
                for (int b = 0; b < 6; b++) begin
                    wr(3'd0, bytes[b]); idle(200);
                    chk("R7 external pin idle", txd, 1);
                    wait_rx(ok); chk("R7 loopback received", ok, 1);
                    rd(3'd7, fl); chk("R6 flags clean", fl, 0);
                    rd(3'd0, v); chk("R2 received data", v, bytes[b] & (8'hFF >> (3 - len)));
                end
                clean();
            end
        end

        // R6 parity mismatch: transmit even, receive odd
        wr(3'd2, 8'h37); wr(3'd1, 8'hFE); wr(3'd0, 8'h96);
        wait_rx(ok); rd(3'd7, fl); chk("R6 parity flag", fl, 1);
        rd(3'd0, v); chk("R6 data kept", v, 8'h96); clean();

        // R6 framing error: break held through a looped-back frame
        wr(3'd1, 8'hB0); wr(3'd2, 8'h77); idle(800); wr(3'd2, 8'h37);
        wait_rx(ok); rd(3'd7, fl); chk("R6 framing flag", fl, 2);
        rd(3'd0, v); chk("R6 framing data", v, 0); clean();

        // R11 receive disabled takes nothing in
        wr(3'd1, 8'hD0); wr(3'd0, 8'h55); idle(900);
        chk("R11 rx disabled", irq_rx, 0); clean();

        // R8/R9 transmit threshold and flush
        wr(3'd4, 8'h20); wr(3'd1, 8'h80); idle(2);
        chk("R9 tx level 0 below 2", irq_tx, 1);
        wr(3'd0, 8'h11); idle(2); chk("R9 tx level 1 below 2", irq_tx, 1);
        wr(3'd0, 8'h22); idle(2); chk("R9 tx level 2 not below 2", irq_tx, 0);
        wr(3'd3, 8'h80); idle(2); chk("R8 tx flush", irq_tx, 1);
        rd(3'd3, v); chk("R8 flush bits clear", v, 0);
        clean();

        // R9/R8 receive threshold and flush
        wr(3'd4, 8'h01); wr(3'd1, 8'hF0); wr(3'd0, 8'h12); idle(750);
        chk("R9 rx level 1 not above 1", irq_rx, 0);
        wr(3'd0, 8'h34); idle(750);
        chk("R9 rx level 2 above 1", irq_rx, 1);
        wr(3'd3, 8'h40); idle(2); chk("R8 rx flush", irq_rx, 0);
        clean();

        // R10 idle timeout of two character times (10-bit frame = 640 clocks each)
        wr(3'd4, 8'h04); wr(3'd3, 8'h02); wr(3'd1, 8'hF0); wr(3'd0, 8'h77);
        idle(700); chk("R10 no early timeout", irq_rx, 0);
        idle(1000); chk("R10 before limit", irq_rx, 0);
        idle(400); chk("R10 timeout raised", irq_rx, 1);
        rd(3'd0, v); chk("R10 data", v, 8'h77);
        idle(2); chk("R10 cleared by read", irq_rx, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule